// File: doc/BRIEF.md
# Gain-Ranging Input Sample Scaler

This block sits at the front of a digital receive chain. Each clock cycle it can accept one converter sample. A sample is made of a signed 16-bit mantissa, an unsigned 3-bit exponent and one select bit. Two configuration inputs, a 3-bit exponent offset and an invert bit, turn the exponent into a shift amount from 0 to 7. The mantissa is then divided by two raised to that amount. The scaled value comes out with seven fractional bits added below the mantissa, so no precision is lost for any shift.

Three input modes decide what the select bit means. In single real mode it is ignored. In interleaved dual real mode it names the antenna channel. In complex mode it separates in-phase samples from quadrature samples. The mode is taken from its configuration pins only while reset is asserted.

A converter narrower than 16 bits is connected MSB-justified, with its unused low bits tied to zero. A fixed-point converter uses a zero exponent, zero offset and a clear invert bit, and its data then passes through with no scaling.

Top module: `gain_range_scaler`

## Requirements
- R1: A sample presented with `in_valid` high at a rising edge appears on the outputs right after that edge. `out_valid` always equals `in_valid` as sampled at the previous edge.
- R2: With `cfg_exp_inv` = 0, the shift amount is (exponent + offset) mod 8.
- R3: With `cfg_exp_inv` = 1, the shift amount is (7 - exponent + offset) mod 8, so a larger exponent gives less attenuation.
- R4: The sum that forms the shift amount wraps modulo 8. For example, exponent 5 with offset 4 gives a shift of 1.
- R5: `out_data` is 23-bit two's complement and equals mantissa × 2^(7 - shift) exactly. The shift is arithmetic, so the sign is preserved.
- R6: With exponent, offset and invert all zero, `out_data` equals the mantissa shifted left by 7.
- R7: In single real mode (`cfg_mode` = 2'b00), and for the reserved code 2'b11, both tag outputs are 0 whatever `in_sel` is.
- R8: In dual real mode (`cfg_mode` = 2'b01), `out_tag_b` copies `in_sel` (1 = channel B) and `out_tag_q` is 0.
- R9: In complex mode (`cfg_mode` = 2'b10), `out_tag_q` copies `in_sel` (1 = Q sample) and `out_tag_b` is 0.
- R10: `cfg_mode` is captured only while `rst` is high. Changes to it outside reset have no effect on the tags.
- R11: After reset, `out_valid`, `out_data` and both tags are 0.
- R12: A cycle with `in_valid` low gives `out_valid` = 0 and leaves `out_data` and the tags at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also captures the mode |
| cfg_mode | input | 2 | Input mode: 00 single real, 01 dual real, 10 complex, 11 treated as 00 |
| cfg_exp_ofs | input | 3 | Exponent offset added before the modulo |
| cfg_exp_inv | input | 1 | Inverts the exponent (7 - exp) before the offset is added |
| in_valid | input | 1 | Marks a sample on the input pins |
| in_mant | input | 16 | Two's-complement mantissa |
| in_exp | input | 3 | Unsigned exponent |
| in_sel | input | 1 | Channel or I/Q select, meaning set by the mode |
| out_valid | output | 1 | Registered sample strobe |
| out_data | output | 23 | Scaled sample, 7 fractional bits |
| out_tag_b | output | 1 | Sample belongs to channel B (dual mode only) |
| out_tag_q | output | 1 | Sample is quadrature (complex mode only) |

## Verification
A faulty shift amount, for example a missing invert, a missing wrap or a lost offset, shows up as a power-of-two error in `out_data` on the very next cycle. A logical shift used in place of an arithmetic one flips the sign bit of negative results in that same cycle. A mode register that is corrupted, or that reloads outside reset, shows up as wrong channel or I/Q tags on the first valid sample after the corruption. A wrong strobe or a failure to hold the data is visible one edge after the input.

// File: rtl/grs_pkg.sv
package grs_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_DUAL = 2'b01,
    MODE_CPLX = 2'b10
  } in_mode_e;
endpackage

// File: rtl/grs_shift_calc.sv
module grs_shift_calc #(
  parameter int EXP_W = 3
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [EXP_W-1:0] ofs_i,
  input  logic             inv_i,
  output logic [EXP_W-1:0] shift_o
);
  logic [EXP_W-1:0] base;
  // ~exp equals (2^EXP_W - 1) - exp; the sum wraps modulo 2^EXP_W by width
  always_comb begin
    base    = inv_i ? ~exp_i : exp_i;
    shift_o = base + ofs_i;
  end
endmodule

// File: rtl/grs_barrel.sv
module grs_barrel #(
  parameter int W    = 23,
  parameter int SH_W = 3
) (
  input  logic signed [W-1:0]    data_i,
  input  logic        [SH_W-1:0] shift_i,
  output logic signed [W-1:0]    data_o
);
  logic signed [W-1:0] stg [SH_W+1];

  assign stg[0] = data_i;

  genvar i;
  generate
    for (i = 0; i < SH_W; i++) begin : g_stage
      assign stg[i+1] = shift_i[i] ? (stg[i] >>> (1 << i)) : stg[i];
    end
  endgenerate

  assign data_o = stg[SH_W];
endmodule

// File: rtl/grs_tag_decode.sv
module grs_tag_decode
  import grs_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sel_i,
  output logic       tag_b_o,
  output logic       tag_q_o
);
  always_comb begin
    tag_b_o = 1'b0;
    tag_q_o = 1'b0;
    case (mode_i)
      MODE_DUAL: tag_b_o = sel_i;
      MODE_CPLX: tag_q_o = sel_i;
      default:   ;
    endcase
  end
endmodule

// File: rtl/gain_range_scaler.sv
module gain_range_scaler #(
  parameter int MANT_W = 16,
  parameter int EXP_W  = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [1:0]                        cfg_mode,
  input  logic [EXP_W-1:0]                  cfg_exp_ofs,
  input  logic                              cfg_exp_inv,
  input  logic                              in_valid,
  input  logic [MANT_W-1:0]                 in_mant,
  input  logic [EXP_W-1:0]                  in_exp,
  input  logic                              in_sel,
  output logic                              out_valid,
  output logic [MANT_W+(2**EXP_W)-2:0]      out_data,
  output logic                              out_tag_b,
  output logic                              out_tag_q
);
  localparam int FRAC_W = (2**EXP_W) - 1;
  localparam int OUT_W  = MANT_W + FRAC_W;

  logic [1:0]              mode_q;
  logic [EXP_W-1:0]        shift;
  logic signed [OUT_W-1:0] wide;
  logic signed [OUT_W-1:0] scaled;
  logic                    tag_b_d;
  logic                    tag_q_d;

  // Mode register: loads only while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= cfg_mode;
  end

  grs_shift_calc #(.EXP_W(EXP_W)) u_shift (
    .exp_i   (in_exp),
    .ofs_i   (cfg_exp_ofs),
    .inv_i   (cfg_exp_inv),
    .shift_o (shift)
  );

  assign wide = {in_mant, {FRAC_W{1'b0}}};

  grs_barrel #(.W(OUT_W), .SH_W(EXP_W)) u_barrel (
    .data_i  (wide),
    .shift_i (shift),
    .data_o  (scaled)
  );

  grs_tag_decode u_tag (
    .mode_i  (mode_q),
    .sel_i   (in_sel),
    .tag_b_o (tag_b_d),
    .tag_q_o (tag_q_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag_b <= 1'b0;
      out_tag_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= scaled;
        out_tag_b <= tag_b_d;
        out_tag_q <= tag_q_d;
      end
    end
  end
endmodule

// File: rtl/gain_range_scaler_chk.sv
module gain_range_scaler_chk #(
  parameter int MANT_W = 16,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = 23
) (
  input logic              clk,
  input logic              rst,
  input logic [EXP_W-1:0]  cfg_exp_ofs,
  input logic              cfg_exp_inv,
  input logic              in_valid,
  input logic [MANT_W-1:0] in_mant,
  input logic [EXP_W-1:0]  in_exp,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_data,
  input logic              out_tag_b,
  input logic              out_tag_q,
  input logic [1:0]        mode_q
);
  localparam int FRAC_W = OUT_W - MANT_W;

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_tag_b) && $stable(out_tag_q)));

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_exp_inv && in_exp == '0 && cfg_exp_ofs == '0)
    |=> out_data == {$past(in_mant), {FRAC_W{1'b0}}});

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_exp_inv && ({1'b0, in_exp} + {1'b0, cfg_exp_ofs}) == (EXP_W+1)'(2**EXP_W))
    |=> out_data == {$past(in_mant), {FRAC_W{1'b0}}});

  // R5
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_data[OUT_W-1] == $past(in_mant[MANT_W-1]));

  // R8 R9
  tag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_tag_b, out_tag_q}));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_tag_b && !out_tag_q));
endmodule

bind gain_range_scaler gain_range_scaler_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_exp_ofs(cfg_exp_ofs), .cfg_exp_inv(cfg_exp_inv),
  .in_valid(in_valid), .in_mant(in_mant), .in_exp(in_exp),
  .out_valid(out_valid), .out_data(out_data), .out_tag_b(out_tag_b),
  .out_tag_q(out_tag_q), .mode_q(mode_q)
);

// File: tb/sim_gain_range_scaler.sv
`timescale 1ns/1ps
module sim_gain_range_scaler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'b00;
  logic [2:0]  cfg_exp_ofs = '0;
  logic        cfg_exp_inv = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_mant = '0;
  logic [2:0]  in_exp = '0;
  logic        in_sel = 1'b0;
  logic        out_valid;
  logic [22:0] out_data;
  logic        out_tag_b;
  logic        out_tag_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gain_range_scaler u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_exp_ofs(cfg_exp_ofs),
    .cfg_exp_inv(cfg_exp_inv), .in_valid(in_valid), .in_mant(in_mant),
    .in_exp(in_exp), .in_sel(in_sel), .out_valid(out_valid),
    .out_data(out_data), .out_tag_b(out_tag_b), .out_tag_q(out_tag_q)
  );

  // {mant[45:30], exp[29:27], ofs[26:24], inv[23], expected[22:0]}
  localparam int NV = 10;
  localparam logic [45:0] VEC [NV] = '{
    {16'h1234, 3'd0, 3'd0, 1'b0, 23'h091A00},  // R6 pass-through
    {16'h4000, 3'd3, 3'd0, 1'b0, 23'h040000},  // R2 shift 3
    {16'h8000, 3'd7, 3'd0, 1'b0, 23'h7F8000},  // R5 negative, shift 7
    {16'h0001, 3'd7, 3'd0, 1'b0, 23'h000001},  // R5 smallest lsb kept
    {16'hFFFF, 3'd5, 3'd4, 1'b0, 23'h7FFFC0},  // R4 wrap to shift 1
    {16'h0100, 3'd0, 3'd0, 1'b1, 23'h000100},  // R3 shift 7
    {16'h0100, 3'd7, 3'd0, 1'b1, 23'h008000},  // R3 shift 0
    {16'h7FFF, 3'd2, 3'd3, 1'b1, 23'h3FFF80},  // R4 inverted wrap to 0
    {16'hC000, 3'd4, 3'd1, 1'b1, 23'h7E0000},  // R3 shift 4 negative
    {16'h0003, 3'd6, 3'd2, 1'b0, 23'h000180}   // R4 wrap to 0
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; cfg_mode = m; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive at a falling edge; the result is sampled one falling edge later
  task automatic drive(input logic v, input logic [15:0] m, input logic [2:0] e,
                       input logic [2:0] o, input logic iv, input logic s);
    @(negedge clk);
    in_valid = v; in_mant = m; in_exp = e; cfg_exp_ofs = o; cfg_exp_inv = iv; in_sel = s;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    do_reset(2'b00);
    // R11 reset state
    check(out_valid == 0 && out_data == 0 && !out_tag_b && !out_tag_q, "R11 reset",
          {out_valid, out_tag_b, out_tag_q, out_data}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][45:30], VEC[i][29:27], VEC[i][26:24], VEC[i][23], 1'b1);
      check(out_valid == 1'b1, "R1 valid", {31'b0, out_valid}, 32'h1);
      check(out_data == VEC[i][22:0], VEC[i][23] ? "R3/R5 scaled" : "R2/R5 scaled",
            {9'b0, out_data}, {9'b0, VEC[i][22:0]});
      check(!out_tag_b && !out_tag_q, "R7 single tags", {30'b0, out_tag_b, out_tag_q}, 32'h0);
    end

    // R12 idle cycle holds data
    drive(1'b0, 16'h5555, 3'd1, 3'd0, 1'b0, 1'b0);
    check(out_valid == 1'b0, "R12 idle valid", {31'b0, out_valid}, 32'h0);
    check(out_data == 23'h000180, "R12 idle hold", {9'b0, out_data}, 32'h180);

    // R8 dual real mode
    do_reset(2'b01);
    drive(1'b1, 16'h0010, 3'd0, 3'd0, 1'b0, 1'b1);
    check(out_tag_b && !out_tag_q, "R8 channel B", {30'b0, out_tag_b, out_tag_q}, 32'h2);
    drive(1'b1, 16'h0010, 3'd0, 3'd0, 1'b0, 1'b0);
    check(!out_tag_b && !out_tag_q, "R8 channel A", {30'b0, out_tag_b, out_tag_q}, 32'h0);

    // R10 mode pins changed outside reset are ignored
    @(negedge clk); cfg_mode = 2'b10;
    drive(1'b1, 16'h0020, 3'd0, 3'd0, 1'b0, 1'b1);
    check(out_tag_b && !out_tag_q, "R10 mode held", {30'b0, out_tag_b, out_tag_q}, 32'h2);

    // R9 complex mode
    do_reset(2'b10);
    drive(1'b1, 16'h0030, 3'd0, 3'd0, 1'b0, 1'b1);
    check(!out_tag_b && out_tag_q, "R9 Q sample", {30'b0, out_tag_b, out_tag_q}, 32'h1);
    drive(1'b1, 16'h0030, 3'd0, 3'd0, 1'b0, 1'b0);
    check(!out_tag_b && !out_tag_q, "R9 I sample", {30'b0, out_tag_b, out_tag_q}, 32'h0);

    // R7 reserved code acts as single real
    do_reset(2'b11);
    drive(1'b1, 16'h0040, 3'd0, 3'd0, 1'b0, 1'b1);
    check(!out_tag_b && !out_tag_q, "R7 reserved tags", {30'b0, out_tag_b, out_tag_q}, 32'h0);

    // R11 reset clears after activity
    do_reset(2'b00);
    check(out_valid == 0 && out_data == 0, "R11 re-reset", {8'b0, out_valid, out_data}, 32'h0);

    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule